// File: doc/BRIEF.md
# Configurable Serial Character Transmitter with Line Break

This block takes characters from software through a one-entry holding buffer, moves each one into a transmit shift register and sends it as an asynchronous serial frame on a single output line. The frame length, the parity mode and the number of stop bits are set by static control inputs. These settings are captured when a character enters the shift register, so changing them mid-frame does not disturb the frame already on the line. A bit-period tick from an external rate generator advances the line by one bit.

A single control input has two roles. With nine-bit framing it supplies the ninth data bit. With seven- or eight-bit framing it is the low bit of the parity mode select. The 2-bit length code has a fourth setting that uses nine-bit framing and also raises a loopback indication for the receive side. A break control pulls the line low for as long as software holds it. The block reports whether the holding buffer is empty and whether a frame is being sent.

Top module: `uart_tx_frame`

## Requirements
- R1: After reset the line output is high, the buffer-empty flag is 1 and the transmitting flag is 0.
- R2: A frame is one low start bit, then the data bits least significant first, then the optional parity bit, then the high stop bits. Length code 00 selects 8 data bits.
- R3: Length code 01 selects 7 data bits, taken from data bits 6..0.
- R4: Length codes 10 and 11 select 9 data bits. The ninth bit is the ninth-bit/parity-select input sampled when the frame loads, and no parity bit is inserted. Code 11 also drives the loopback output high.
- R5: With parity enabled and 7 or 8 data bits, one parity bit follows the data. The mode {psel1_i, bit9_psel0_i} is 00 odd (data plus parity has an odd count of ones), 01 even, 10 mark (always 1) or 11 space (always 0).
- R6: stop2_i = 0 sends one stop bit and stop2_i = 1 sends two.
- R7: The buffer-empty flag reads 0 from the cycle after a buffer write. It returns to 1 in the cycle after the character moves into the shift register, which happens on the first clock edge at which the transmitter is idle, or on the tick that ends a stop bit.
- R8: The transmitting flag rises together with the start bit. It falls on the tick that ends the last stop bit when the buffer is empty, and the line then idles high.
- R9: If the buffer holds a character when a frame's last stop bit ends, the next start bit follows on that same edge with no idle bit time, and the transmitting flag stays high.
- R10: While brk_i is 1 the line output is 0, in idle and mid-frame alike. Frame timing carries on underneath, and the line shows the current frame bit again when brk_i is released.
- R11: The line changes only on the edge after a tick or after a frame load. Between ticks it is stable.
- R12: A write to a full buffer replaces the waiting character, so the most recent write is the one sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| wr_stb_i | input | 1 | Holding buffer write strobe |
| wr_data_i | input | BYTE_W | Character written to the buffer |
| bit9_psel0_i | input | 1 | Ninth data bit (9-bit framing) or parity select low bit |
| psel1_i | input | 1 | Parity select high bit |
| par_en_i | input | 1 | Parity enable for 7- and 8-bit framing |
| stop2_i | input | 1 | Two stop bits when 1 |
| brk_i | input | 1 | Hold the line low |
| fmt_i | input | 2 | Frame length code |
| txd_o | output | 1 | Serial output line |
| buf_empty_o | output | 1 | Holding buffer empty |
| busy_o | output | 1 | Frame in progress |
| loop_o | output | 1 | Loopback setting selected |

## Verification
The bench builds the block with BYTE_W = 8. With that width the longest frames, 12 bits in both the 9-bit two-stop case and the 8-bit parity two-stop case, and the shortest frame, 9 bits in the 7-bit one-stop case, are all exercised. Because the bench drives every tick itself, it can line up a buffered character with the last stop-bit tick and confirm that the next frame follows with no gap. It also checks that the line holds still across the cycles between ticks.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    FMT_LEN8 = 2'b00,
    FMT_LEN7 = 2'b01,
    FMT_LEN9 = 2'b10,
    FMT_LOOP = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_MARK  = 2'b10,
    PAR_SPACE = 2'b11
  } par_e;
endpackage

// File: rtl/uart_tx_rst_sync.sv
module uart_tx_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/uart_tx_holdbuf.sv
module uart_tx_holdbuf #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              full_o
);
  logic [BYTE_W-1:0] data_q, data_d;
  logic              full_q, full_d;

  always_comb begin
    data_d = data_q;
    full_d = full_q;
    if (take_i)   full_d = 1'b0;
    if (wr_stb_i) begin
      data_d = wr_data_i;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      data_q <= data_d;
      full_q <= full_d;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned FRAME_W = BYTE_W + 4,
  parameter int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [BYTE_W-1:0]  data_i,
  input  logic [1:0]         fmt_i,
  input  logic               bit9_psel0_i,
  input  logic               psel1_i,
  input  logic               par_en_i,
  input  logic               stop2_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   nbits_o
);
  localparam int unsigned EXT_W = BYTE_W + 1;

  logic [EXT_W-1:0] ext;
  logic [CNT_W-1:0] dbits;
  logic             par_on;
  logic             ones_odd;
  logic             par_bit;
  par_e             par_mode;

  assign ext      = {bit9_psel0_i, data_i};
  assign par_mode = par_e'({psel1_i, bit9_psel0_i});

  always_comb begin
    unique case (fmt_e'(fmt_i))
      FMT_LEN7: dbits = CNT_W'(BYTE_W - 1);
      FMT_LEN8: dbits = CNT_W'(BYTE_W);
      default:  dbits = CNT_W'(BYTE_W + 1);
    endcase
    par_on = par_en_i && (dbits != CNT_W'(BYTE_W + 1));
  end

  always_comb begin
    ones_odd = 1'b0;
    for (int i = 0; i < EXT_W; i++) begin
      if (CNT_W'(i) < dbits) ones_odd = ones_odd ^ ext[i];
    end
    unique case (par_mode)
      PAR_ODD:   par_bit = ~ones_odd;
      PAR_EVEN:  par_bit = ones_odd;
      PAR_MARK:  par_bit = 1'b1;
      default:   par_bit = 1'b0;
    endcase
  end

  always_comb begin
    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < EXT_W; i++) begin
      if (CNT_W'(i) < dbits) frame_o[i+1] = ext[i];
    end
    if (par_on) frame_o[dbits + CNT_W'(1)] = par_bit;
    nbits_o = CNT_W'(2) + dbits + CNT_W'(par_on) + CNT_W'(stop2_i);
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               avail_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   nbits_i,
  output logic               take_o,
  output logic               line_o,
  output logic               busy_o
);
  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               busy_q, busy_d;
  logic               shift_en;
  logic               last_bit;

  assign shift_en = busy_q && tick_i;
  assign last_bit = shift_en && (cnt_q == CNT_W'(1));
  assign take_o   = avail_i && (!busy_q || last_bit);

  always_comb begin
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (take_o) begin
      sreg_d = frame_i;
      cnt_d  = nbits_i;
      busy_d = 1'b1;
    end else if (shift_en) begin
      sreg_d = {1'b1, sreg_q[FRAME_W-1:1]};
      cnt_d  = cnt_q - CNT_W'(1);
      busy_d = !last_bit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign line_o = busy_q ? sreg_q[0] : 1'b1;
  assign busy_o = busy_q;
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              wr_stb_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              bit9_psel0_i,
  input  logic              psel1_i,
  input  logic              par_en_i,
  input  logic              stop2_i,
  input  logic              brk_i,
  input  logic [1:0]        fmt_i,
  output logic              txd_o,
  output logic              buf_empty_o,
  output logic              busy_o,
  output logic              loop_o
);
  localparam int unsigned FRAME_W = BYTE_W + 4;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic               rst_sync_n;
  logic [BYTE_W-1:0]  buf_data;
  logic               buf_full;
  logic               take;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  logic               line;

  uart_tx_rst_sync rst_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  uart_tx_holdbuf #(.BYTE_W(BYTE_W)) hold_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .wr_stb_i  (wr_stb_i),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .data_o    (buf_data),
    .full_o    (buf_full)
  );

  uart_tx_framer #(.BYTE_W(BYTE_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) frm_i (
    .data_i       (buf_data),
    .fmt_i        (fmt_i),
    .bit9_psel0_i (bit9_psel0_i),
    .psel1_i      (psel1_i),
    .par_en_i     (par_en_i),
    .stop2_i      (stop2_i),
    .frame_o      (frame),
    .nbits_o      (nbits)
  );

  uart_tx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) shf_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .tick_i  (bit_tick_i),
    .avail_i (buf_full),
    .frame_i (frame),
    .nbits_i (nbits),
    .take_o  (take),
    .line_o  (line),
    .busy_o  (busy_o)
  );

  assign txd_o       = line & ~brk_i;
  assign buf_empty_o = ~buf_full;
  assign loop_o      = (fmt_i == 2'b11);
endmodule

// File: rtl/uart_tx_frame_chk.sv
module uart_tx_frame_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_tick_i,
  input logic wr_stb_i,
  input logic brk_i,
  input logic txd_o,
  input logic buf_empty_o,
  input logic busy_o
);
  // R10
  brk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |-> !txd_o);

  // R8
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !brk_i) |-> txd_o);

  // R11
  hold_between_ticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && !$past(bit_tick_i) && !brk_i && !$past(brk_i)) |-> $stable(txd_o));

  // R7
  empty_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |=> !buf_empty_o);

  // R7
  empty_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_empty_o) |-> busy_o);

  // R8
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && !brk_i) |-> !txd_o);
endmodule

bind uart_tx_frame uart_tx_frame_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_sync_n),
  .bit_tick_i  (bit_tick_i),
  .wr_stb_i    (wr_stb_i),
  .brk_i       (brk_i),
  .txd_o       (txd_o),
  .buf_empty_o (buf_empty_o),
  .busy_o      (busy_o)
);

// File: tb/uart_tx_frame_tb_top.sv
module uart_tx_frame_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       b9 = 1'b0;
  logic       ps1 = 1'b0;
  logic       pen = 1'b0;
  logic       stp2 = 1'b0;
  logic       brk = 1'b0;
  logic [1:0] fmt = 2'b00;
  logic       txd, empty, busy, loopb;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  logic [15:0] exp_bits;
  int          exp_n;

  always #5 clk = ~clk;

  uart_tx_frame #(.BYTE_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .wr_stb_i(wr),
    .wr_data_i(wdata), .bit9_psel0_i(b9), .psel1_i(ps1), .par_en_i(pen),
    .stop2_i(stp2), .brk_i(brk), .fmt_i(fmt), .txd_o(txd),
    .buf_empty_o(empty), .busy_o(busy), .loop_o(loopb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [7:0] d);
    int dn, idx, ones;
    logic [8:0] d9;
    logic p;
    dn = (fmt == 2'b01) ? 7 : (fmt == 2'b00) ? 8 : 9;
    d9 = {b9, d};
    exp_bits = '1;
    idx = 0;
    exp_bits[idx] = 1'b0; idx++;
    ones = 0;
    for (int i = 0; i < dn; i++) begin
      exp_bits[idx] = d9[i]; idx++;
      ones += d9[i];
    end
    if (pen && dn < 9) begin
      case ({ps1, b9})
        2'b00: p = (ones % 2 == 0);
        2'b01: p = (ones % 2 == 1);
        2'b10: p = 1'b1;
        default: p = 1'b0;
      endcase
      exp_bits[idx] = p; idx++;
    end
    exp_n = idx + 1 + (stp2 ? 1 : 0);
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk) begin wr = 1'b1; wdata = d; end
    @(negedge clk) wr = 1'b0;
  endtask

  // sends bits 0..n-2 checking each, leaves the last stop bit on the line
  task automatic walk_bits(input string tag);
    for (int k = 0; k < exp_n; k++) begin
      chk(txd === exp_bits[k], tag, txd, exp_bits[k]);
      @(negedge clk);
      @(negedge clk);
      chk(txd === exp_bits[k], "R11 hold", txd, exp_bits[k]);
      if (k < exp_n - 1) do_tick();
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input string tag);
    model(d);
    do_write(d);
    chk(empty === 1'b0, "R7 empty clears", empty, 0);
    @(negedge clk);
    chk(empty === 1'b1 && busy === 1'b1, "R7/R8 load", {empty, busy}, 3);
    walk_bits(tag);
    do_tick();
    chk(busy === 1'b0 && txd === 1'b1, "R8 end of frame", {busy, txd}, 1);
  endtask

  task automatic t_reset();
    chk(txd === 1'b1 && empty === 1'b1 && busy === 1'b0, "R1 reset", {txd, empty, busy}, 6);
  endtask

  task automatic t_formats();
    b9 = 0; ps1 = 0; pen = 0; stp2 = 0;
    fmt = 2'b00; send_frame(8'hA5, "R2 8-bit");
    fmt = 2'b00; send_frame(8'h3C, "R2 8-bit b");
    fmt = 2'b01; send_frame(8'hD3, "R3 7-bit");
    fmt = 2'b10; b9 = 1; send_frame(8'h5A, "R4 9-bit b9=1");
    fmt = 2'b10; b9 = 0; pen = 1; send_frame(8'hFF, "R4 9-bit no parity");
    fmt = 2'b11; b9 = 1; pen = 0;
    chk(loopb === 1'b1, "R4 loop flag", loopb, 1);
    send_frame(8'h81, "R4 loop 9-bit");
    fmt = 2'b00;
    chk(loopb === 1'b0, "R4 loop flag off", loopb, 0);
  endtask

  task automatic t_parity();
    fmt = 2'b00; pen = 1; stp2 = 0;
    ps1 = 0; b9 = 0; send_frame(8'h07, "R5 odd");
    ps1 = 0; b9 = 1; send_frame(8'h07, "R5 even");
    ps1 = 1; b9 = 0; send_frame(8'h00, "R5 mark");
    ps1 = 1; b9 = 1; send_frame(8'hFF, "R5 space");
    fmt = 2'b01; ps1 = 0; b9 = 0; send_frame(8'h81, "R5 odd 7-bit");
    fmt = 2'b01; ps1 = 0; b9 = 1; send_frame(8'hC1, "R5 even 7-bit");
    pen = 0; ps1 = 0; b9 = 0; fmt = 2'b00;
  endtask

  task automatic t_stops();
    fmt = 2'b00; stp2 = 1; send_frame(8'h96, "R6 two stops");
    fmt = 2'b00; pen = 1; send_frame(8'h96, "R6 two stops parity");
    fmt = 2'b10; pen = 0; b9 = 1; send_frame(8'h01, "R6 two stops 9-bit");
    stp2 = 0; b9 = 0; fmt = 2'b00;
  endtask

  task automatic t_back_to_back();
    logic [15:0] first;
    int n1;
    model(8'h55);
    first = exp_bits; n1 = exp_n;
    do_write(8'h55);
    @(negedge clk);
    do_write(8'hC3);
    chk(empty === 1'b0, "R9 second buffered", empty, 0);
    exp_bits = first; exp_n = n1;
    walk_bits("R9 first frame");
    model(8'hC3);
    do_tick();
    chk(busy === 1'b1 && txd === 1'b0, "R9 no gap", {busy, txd}, 2);
    chk(empty === 1'b1, "R9 buffer taken", empty, 1);
    walk_bits("R9 second frame");
    do_tick();
    chk(busy === 1'b0, "R9 idle after", busy, 0);
  endtask

  task automatic t_overwrite();
    model(8'h0F);
    do_write(8'h0F);
    @(negedge clk);
    do_write(8'h11);
    do_write(8'hE4);
    walk_bits("R12 first");
    model(8'hE4);
    do_tick();
    walk_bits("R12 last write wins");
    do_tick();
    chk(busy === 1'b0, "R12 idle", busy, 0);
  endtask

  task automatic t_break();
    brk = 1'b1;
    @(negedge clk);
    chk(txd === 1'b0, "R10 idle break", txd, 0);
    brk = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R10 idle release", txd, 1);
    model(8'hFF);
    do_write(8'hFF);
    @(negedge clk);
    do_tick();
    do_tick();
    brk = 1'b1;
    @(negedge clk);
    chk(txd === 1'b0, "R10 mid-frame break", txd, 0);
    do_tick();
    brk = 1'b0;
    @(negedge clk);
    chk(txd === exp_bits[3] && busy === 1'b1, "R10 resume bit", txd, exp_bits[3]);
    for (int k = 3; k < exp_n; k++) do_tick();
    chk(busy === 1'b0 && txd === 1'b1, "R10 frame completes", {busy, txd}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_formats();
    t_parity();
    t_stops();
    t_back_to_back();
    t_overwrite();
    t_break();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule